// File: doc/BRIEF.md
# Hybrid Hardware/Software Clock Gate

This block gates a set of independent source clocks. Each gated clock owns one 32-bit control word. That word holds an enable bit, a control-select bit and a read-only status bit. When the select bit is 1, software turns the clock on or off with the enable bit. When the select bit is 0, a request pin from the consuming logic turns the clock on or off without software. The status bit shows the real state of the gate. It is brought back into the register clock domain, so software can poll it until it matches the state it asked for.

The chosen request reaches each source clock domain through a two-flop synchroniser. It then drives a latch that is open only while the source clock is low. The output clock is the AND of the source clock and the latch. A new gate state therefore takes effect only on a whole clock period, and the output carries no runt pulse. A source that is configured without a gate passes straight through and always reports itself enabled.

Word 0 of the register space is an access word. The block leaves reset locked, and register writes take effect only after the unlock password is written to word 0. Writing any other value to word 0 locks the block again. A write to a control word while the block is locked is dropped and sets a sticky error flag.

Top module: `hybrid_clk_gate`

## Requirements
- R1: After reset, the block is locked and the error flag is 0. Every control word holds select=1 and enable=1. Each gated clock starts running, and its status reads 1 within 12 register-clock cycles.
- R2: Control word i sits at word address i+1. Its enable bit is at bit EN_BIT (bench: 0), its select bit at bit SEL_BIT (bench: 1) and its status bit at bit STAT_BIT (bench: 4). All other bits read 0, and a write to the status bit has no effect.
- R3: With select=1, enable=0 stops the output clock, which then stays low, and the status bit reads 0. Enable=1 runs the clock again, and the status bit reads 1.
- R4: Writing PASSWORD to word 0 unlocks the block. A read of word 0 returns bit 0 = unlocked and bit 1 = error flag; all other bits read 0.
- R5: A write to a control word while the block is locked leaves that word and the output clock unchanged.
- R6: A write to a control word while the block is locked sets the error flag. The flag stays set, even across a later unlock, until reset.
- R7: Writing any value other than PASSWORD to word 0 locks the block.
- R8: With select=0, the request pin of that clock alone decides whether the clock runs, and the enable bit is ignored. The status bit follows the gate.
- R9: The status bit does not change in the first register-clock cycle after the write that changes the request. It reaches the new state within 12 register-clock cycles.
- R10: The gate state changes only while the source clock is low. Every high pulse on a gated output lasts a full half period of its source clock.
- R11: A clock whose bit in GATED is 0 is passed through without change. Its status always reads 1, and its enable and select bits, though stored, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| clk_src | input | NCLK | Source clocks, one per gate |
| hw_req | input | NCLK | Automatic run requests from the consuming logic, asynchronous |
| gclk | output | NCLK | Gated output clocks |

## Verification
The bench builds the block with NCLK=3 and GATED=3'b011. Clocks 0 and 1 therefore have real gates, and clock 2 is a pass-through. This brings the ungated case of R11 within reach alongside software and hardware control of separate gates. The source clocks run at periods of 14, 16 and 18 against a register clock of 10, so every request has to cross a real clock-domain boundary. The bit positions stay at EN_BIT=0, SEL_BIT=1 and STAT_BIT=4, with a 32-bit password. The bench exercises both a wrong access value and writes that set every bit of a control word.

// File: rtl/hybrid_clk_gate_pkg.sv
package hybrid_clk_gate_pkg;
  typedef struct packed {
    logic sel;
    logic en;
  } gate_ctl_t;
endpackage

// File: rtl/hcg_regs.sv
module hcg_regs
  import hybrid_clk_gate_pkg::*;
#(
  parameter int          NCLK     = 4,
  parameter int          ADDR_W   = 4,
  parameter int          EN_BIT   = 0,
  parameter int          SEL_BIT  = 1,
  parameter int          STAT_BIT = 4,
  parameter logic [31:0] PASSWORD = 32'hA5C3_0F1E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  input  logic [NCLK-1:0]      status,
  output gate_ctl_t [NCLK-1:0] ctl,
  output logic                 unlocked,
  output logic                 wr_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      wr_err   <= 1'b0;
      for (int i = 0; i < NCLK; i++) begin
        ctl[i].en  <= 1'b1;
        ctl[i].sel <= 1'b1;
      end
    end else if (wr_en) begin
      if (wr_addr == '0) begin
        unlocked <= (wr_data == PASSWORD);
      end else if (!unlocked) begin
        wr_err <= 1'b1;
      end else begin
        for (int i = 0; i < NCLK; i++) begin
          if (wr_addr == ADDR_W'(i + 1)) begin
            ctl[i].en  <= wr_data[EN_BIT];
            ctl[i].sel <= wr_data[SEL_BIT];
          end
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) begin
      rd_data[0] = unlocked;
      rd_data[1] = wr_err;
    end
    for (int i = 0; i < NCLK; i++) begin
      if (rd_addr == ADDR_W'(i + 1)) begin
        rd_data[EN_BIT]   = ctl[i].en;
        rd_data[SEL_BIT]  = ctl[i].sel;
        rd_data[STAT_BIT] = status[i];
      end
    end
  end
endmodule

// File: rtl/hcg_cell.sv
module hcg_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_src,
  input  logic req,
  output logic gclk,
  output logic gate_on,
  output logic status
);
  logic [SYNC_STAGES-1:0] req_sync;
  logic [1:0]             stat_sync;

  // request crossing into the source clock domain
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) req_sync <= '0;
    else        req_sync <= {req_sync[SYNC_STAGES-2:0], req};
  end

  // transparent only while the source clock is low
  always_latch begin
    if (!rst_n)        gate_on = 1'b0;
    else if (!clk_src) gate_on = req_sync[SYNC_STAGES-1];
  end

  assign gclk = clk_src & gate_on;

  // gate state back into the register domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_sync <= '0;
    else        stat_sync <= {stat_sync[0], gate_on};
  end

  assign status = stat_sync[1];
endmodule

// File: rtl/hybrid_clk_gate.sv
module hybrid_clk_gate
  import hybrid_clk_gate_pkg::*;
#(
  parameter int             NCLK        = 4,
  parameter int             ADDR_W      = 4,
  parameter int             EN_BIT      = 0,
  parameter int             SEL_BIT     = 1,
  parameter int             STAT_BIT    = 4,
  parameter int             SYNC_STAGES = 2,
  parameter logic [31:0]    PASSWORD    = 32'hA5C3_0F1E,
  parameter logic [NCLK-1:0] GATED      = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NCLK-1:0]   clk_src,
  input  logic [NCLK-1:0]   hw_req,
  output logic [NCLK-1:0]   gclk
);
  gate_ctl_t [NCLK-1:0] ctl;
  logic [NCLK-1:0]      status;
  logic [NCLK-1:0]      gate_on;
  logic                 unlocked;
  logic                 wr_err;

  hcg_regs #(
    .NCLK(NCLK), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT), .SEL_BIT(SEL_BIT),
    .STAT_BIT(STAT_BIT), .PASSWORD(PASSWORD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .status(status), .ctl(ctl), .unlocked(unlocked), .wr_err(wr_err)
  );

  for (genvar g = 0; g < NCLK; g++) begin : g_gate
    if (GATED[g]) begin : g_real
      logic req;
      assign req = ctl[g].sel ? ctl[g].en : hw_req[g];
      hcg_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk(clk), .rst_n(rst_n), .clk_src(clk_src[g]), .req(req),
        .gclk(gclk[g]), .gate_on(gate_on[g]), .status(status[g])
      );
    end else begin : g_pass
      logic unused_req;
      assign unused_req = hw_req[g];
      assign gclk[g]    = clk_src[g];
      assign gate_on[g] = 1'b1;
      assign status[g]  = 1'b1;
    end
  end
endmodule

// File: rtl/hybrid_clk_gate_chk.sv
module hybrid_clk_gate_chk
  import hybrid_clk_gate_pkg::*;
#(
  parameter int              NCLK     = 4,
  parameter int              ADDR_W   = 4,
  parameter logic [31:0]     PASSWORD = 32'hA5C3_0F1E,
  parameter logic [NCLK-1:0] GATED    = '1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [31:0]          wr_data,
  input logic [NCLK-1:0]      clk_src,
  input gate_ctl_t [NCLK-1:0] ctl,
  input logic                 unlocked,
  input logic                 wr_err,
  input logic [NCLK-1:0]      gate_on
);
  // R5
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && wr_addr != '0) |=> $stable(ctl));

  // R6
  locked_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && wr_addr != '0) |=> wr_err);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  // R4
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_data == PASSWORD) |=> unlocked);

  // R7
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_data != PASSWORD) |=> !unlocked);

  for (genvar g = 0; g < NCLK; g++) begin : g_chk
    if (GATED[g]) begin : g_real
      logic held;
      always_ff @(posedge clk_src[g] or negedge rst_n) begin
        if (!rst_n) held <= 1'b0;
        else        held <= gate_on[g];
      end
      // R10
      gate_high_stable_chk: assert property (@(negedge clk_src[g]) disable iff (!rst_n)
        gate_on[g] == held);
    end
  end
endmodule

bind hybrid_clk_gate hybrid_clk_gate_chk #(
  .NCLK(NCLK), .ADDR_W(ADDR_W), .PASSWORD(PASSWORD), .GATED(GATED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .clk_src(clk_src), .ctl(ctl), .unlocked(unlocked),
  .wr_err(wr_err), .gate_on(gate_on)
);

// File: tb/hybrid_clk_gate_test.sv
module hybrid_clk_gate_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          NCLK   = 3;
  localparam int          ADDR_W = 4;
  localparam logic [31:0] PW     = 32'hA5C3_0F1E;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  logic [NCLK-1:0]   clk_src = '0;
  logic [NCLK-1:0]   hw_req = '0;
  logic [NCLK-1:0]   gclk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit mon_on = 1'b1;
  int e0 = 0, e1 = 0, e2 = 0;
  int bad0 = 0, bad1 = 0, bad2 = 0;
  longint r0 = 0, r1 = 0, r2 = 0;

  hybrid_clk_gate #(
    .NCLK(NCLK), .ADDR_W(ADDR_W), .EN_BIT(0), .SEL_BIT(1), .STAT_BIT(4),
    .PASSWORD(PW), .GATED(3'b011)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clk_src(clk_src), .hw_req(hw_req), .gclk(gclk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always #7 clk_src[0] = ~clk_src[0];
  always #8 clk_src[1] = ~clk_src[1];
  always #9 clk_src[2] = ~clk_src[2];

  always @(posedge gclk[0]) begin e0++; r0 = $time; end
  always @(posedge gclk[1]) begin e1++; r1 = $time; end
  always @(posedge gclk[2]) begin e2++; r2 = $time; end
  always @(negedge gclk[0]) if (mon_on && ($time - r0) != 7) bad0++;
  always @(negedge gclk[1]) if (mon_on && ($time - r1) != 8) bad1++;
  always @(negedge gclk[2]) if (mon_on && ($time - r2) != 9) bad2++;

  function automatic int edges(int idx);
    case (idx)
      0: return e0;
      1: return e1;
      default: return e2;
    endcase
  endfunction

  task automatic clear_edges();
    e0 = 0; e1 = 0; e2 = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // poll the status bit of gate idx; returns cycles taken, or 99 on timeout
  task automatic poll(int idx, logic want, output int took);
    logic [31:0] d;
    took = 99;
    for (int i = 0; i < 12; i++) begin
      rd(ADDR_W'(idx + 1), d);
      if (d[4] == want) begin took = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);
    check("R1 access word after reset", d, 32'h0);
    rd(1, d);
    check("R1 gate0 ctl bits after reset", d & 32'hFFFF_FFEF, 32'h3);
    rd(3, d);
    check("R11 ungated status at reset", d, 32'h13);
    wait_cycles(12);
    rd(1, d);
    check("R1 R2 gate0 running after reset", d, 32'h13);
    rd(2, d);
    check("R1 gate1 running after reset", d, 32'h13);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    wr(1, 32'h0);
    rd(1, d);
    check("R5 locked write ignored", d, 32'h13);
    rd(0, d);
    check("R6 error flag set by locked write", d, 32'h2);
    clear_edges();
    wait_cycles(10);
    check("R5 clock still runs", 32'(edges(0) > 0), 32'h1);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    wr(0, PW);
    rd(0, d);
    check("R4 R6 unlocked, error kept", d, 32'h3);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    int took;
    wr(1, 32'h2);
    rd(1, d);
    check("R9 status not yet changed", d, 32'h12);
    poll(0, 1'b0, took);
    check("R3 R9 status reaches off", 32'(took < 12), 32'h1);
    clear_edges();
    wait_cycles(10);
    check("R3 gated clock stopped", 32'(edges(0)), 32'h0);
    check("R3 gated clock low", 32'(gclk[0]), 32'h0);
    check("R3 other gate unaffected", 32'(edges(1) > 0), 32'h1);
    wr(1, 32'h3);
    poll(0, 1'b1, took);
    check("R3 R9 status reaches on", 32'(took < 12), 32'h1);
    clear_edges();
    wait_cycles(10);
    check("R3 gated clock restarted", 32'(edges(0) > 0), 32'h1);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d);
    check("R2 only defined bits stored", d, 32'h13);
  endtask

  task automatic t_hw();
    logic [31:0] d;
    int took;
    hw_req[1] = 1'b0;
    wr(2, 32'h1);
    poll(1, 1'b0, took);
    check("R8 hw request low gates off", 32'(took < 12), 32'h1);
    clear_edges();
    wait_cycles(10);
    check("R8 clock stopped under hw", 32'(edges(1)), 32'h0);
    hw_req[1] = 1'b1;
    poll(1, 1'b1, took);
    check("R8 hw request high gates on", 32'(took < 12), 32'h1);
    wr(2, 32'h0);
    wait_cycles(8);
    clear_edges();
    wait_cycles(10);
    check("R8 enable bit ignored under hw", 32'(edges(1) > 0), 32'h1);
    rd(2, d);
    check("R8 status follows gate", d, 32'h10);
  endtask

  task automatic t_ungated();
    logic [31:0] d;
    wr(3, 32'h2);
    wait_cycles(8);
    clear_edges();
    wait_cycles(10);
    check("R11 ungated clock keeps running", 32'(edges(2) > 0), 32'h1);
    rd(3, d);
    check("R11 ungated status stays 1", d, 32'h12);
  endtask

  task automatic t_relock();
    logic [31:0] d;
    wr(0, 32'h0000_1234);
    rd(0, d);
    check("R7 wrong value relocks", d, 32'h2);
    wr(1, 32'h2);
    rd(1, d);
    check("R7 R5 write after relock ignored", d, 32'h13);
    clear_edges();
    wait_cycles(10);
    check("R7 clock still runs after relock", 32'(edges(0) > 0), 32'h1);
  endtask

  task automatic t_pulses();
    check("R10 gate0 full pulses", 32'(bad0), 32'h0);
    check("R10 gate1 full pulses", 32'(bad1), 32'h0);
    check("R10 pass-through full pulses", 32'(bad2), 32'h0);
  endtask

  task automatic t_rereset();
    logic [31:0] d;
    mon_on = 1'b0;
    rst_n = 1'b0;
    wait_cycles(2);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, d);
    check("R6 error cleared only by reset", d, 32'h0);
  endtask

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_sw();
    t_hw();
    t_ungated();
    t_relock();
    t_pulses();
    t_rereset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule